// File: doc/BRIEF.md
# System Control Register Bank

A 32-bit control and status register bank for a small secure microcontroller subsystem. Software reaches it over a simple word-addressed bus: a read strobe, a write strobe with four byte-lane enables, a 12-bit byte offset and 32-bit data. Read data and a one-cycle error flag come back on the clock edge that follows the strobe. The bank holds a debug-enable word, with separate set and clear ports, and reset cause, reset mask and general retention words. It also holds two initial vector-offset words, per-core hold bits, a power-control word, power-domain sense words and a row of constant identification words.

A static parameter selects one of three hardware variants (0, 1, 2). The variant decides which offsets exist. Some registers sit at a different offset on variant 2. Variant 2 also adds a lock bit on the first vector word and an access-unlock bit on the power-control word. Clearing a core's hold bit pulses that core's power-on-and-reset output. A write to the software-reset bit pulses a system reset request. Clock division, power sequencing and reset generation are left to other logic. This block only exports the control values.

Top module: `sysctl_bank`

## Requirements
- R1: After reset the reset-cause word (0x100) reads 1, power control (0x1FC) reads 0x3, system power-domain sense (0x200) reads 0x7F, both vector words read VEC0_RST/VEC1_RST (default 0x10000000), the hold word reads HOLD_RST (default 0) and all other storage reads 0.
- R2: Offset 0x000 returns the debug-enable word and ignores writes (error flag). A write to 0x004 ORs the enabled data bits into it. A write to 0x008 clears every enabled bit written as 1. Reads of 0x004 and 0x008 return 0 with the error flag. Output dbg_en mirrors the word.
- R3: A write to 0x108 whose byte lane 1 is enabled with data bit 9 set raises sys_reset_req for exactly the cycle after the write. Every other bit is ignored, and reads return 0 with the error flag.
- R4: Writable words update only the enabled byte lanes. Reads return the whole word one cycle after rd_en.
- R5: On variant 2, bit 0 of the word at 0x110 is a lock. While it is set, writes are ignored and flagged, and init_vec0 carries bits [31:7] with zeros below. On variants 0 and 1 the whole word is written and exported.
- R6: The hold word covers cores 0 and 1 on variants 0 and 1, and only core 0 on variant 2. When a covered hold bit goes from 1 to 0, core_release for that core is high for one cycle, the same cycle in which the new hold value is visible.
- R7: On variant 2 the hold word sits at 0x120, 0x124 is the NMI-enable word, and 0x114, 0x118 and 0x11C are invalid. On variants 0 and 1 the hold word sits at 0x118. On variant 1, 0x11C is NMI-enable, 0x120 is wake control and 0x124 is extended wake control.
- R8: On variant 2 the word at 0x1FC ignores and flags writes while its bit 0 is clear. On variants 0 and 1 the offset is invalid. pwr_ctl exports bits [1:0].
- R9: On variant 0, 0x11C reads 0 without error and flags writes. Offsets 0x00C–0x018, 0x114, 0x124 and 0x200–0x218 are invalid. Variant 1 has sense words at 0x200, 0x20C, 0x210, 0x214 and 0x218. Variant 2 has them at 0x200, 0x204, 0x214 and 0x218.
- R10: Offsets 0xFD0–0xFFC return, in address order, the bytes 04,00,00,00,54,B8,ID,00,0D,F0,05,B1, zero-extended to 32 bits, where ID is 0x0B on variant 0 and 0x1B otherwise. Writes are ignored and flagged.
- R11: Reads of invalid or misaligned offsets (offset bits [1:0] not zero) return 0. Writes to them change nothing. Every rejected access raises err for the one cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 12 | Byte offset |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Byte-lane enables for writes |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| err | output | 1 | Rejected-access pulse |
| sys_reset_req | output | 1 | System reset request pulse |
| core_hold | output | MAX_CORES | Per-core hold bits |
| core_release | output | MAX_CORES | Per-core power-on-and-reset pulse |
| init_vec0 | output | 32 | Exported initial vector, core 0 |
| init_vec1 | output | 32 | Exported initial vector, core 1 |
| dbg_en | output | 32 | Debug-enable word |
| pwr_ctl | output | 2 | Power-control unlock and filter bits |

## Verification
Corrupted storage shows up on the exported control ports at the write edge itself. A wrong decode shows up on rdata and err one cycle after the strobe. After every write the bench compares dbg_en, init_vec0, init_vec1, pwr_ctl and core_hold with a per-variant model, and it reads back every accessed offset, so a stray lane update, a missed lock or an alias pointed at the wrong word is caught within two cycles. Three instances, one per variant, see the same bus traffic, so a decode that leaks from one variant into another produces a mismatch on the others.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
    localparam int DW    = 32;
    localparam int AW    = 12;
    localparam int NSLOT = 21;

    typedef enum logic [3:0] {
        K_BAD, K_RW, K_RO, K_ZERO, K_SET, K_CLR, K_SWRST,
        K_HOLD, K_VLOCK, K_PLOCK, K_ID
    } kind_e;

    typedef enum logic [4:0] {
        S_DBG, S_SEC, S_FDIV, S_SDIV, S_CFRC, S_RSYN, S_RMSK, S_RET,
        S_VEC0, S_VEC1, S_HOLD, S_NMI, S_WAKE, S_EWC, S_PWR,
        S_SSYS, S_SCPU, S_SR0, S_SR1, S_SR2, S_SR3, S_NONE
    } slot_e;

    typedef struct packed {
        logic [NSLOT-1:0][DW-1:0] r;
        logic [DW-1:0]            rdata;
        logic                     err;
        logic                     rstreq;
    } bank_t;

    function automatic logic [DW-1:0] lane_mask(input logic [DW/8-1:0] s);
        logic [DW-1:0] m;
        for (int i = 0; i < DW/8; i++) m[i*8 +: 8] = {8{s[i]}};
        return m;
    endfunction
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int VARIANT = 1
) (
    input  logic [AW-1:0] addr,
    output kind_e         kind,
    output slot_e         slot,
    output logic [3:0]    id_idx
);
    localparam bit V0 = (VARIANT == 0);
    localparam bit V1 = (VARIANT == 1);
    localparam bit V2 = (VARIANT == 2);

    always_comb begin
        kind   = K_BAD;
        slot   = S_NONE;
        id_idx = addr[5:2] - 4'd4;
        case (addr)
            12'h000: begin kind = K_RO;  slot = S_DBG; end
            12'h004: begin kind = K_SET; slot = S_DBG; end
            12'h008: begin kind = K_CLR; slot = S_DBG; end
            12'h00C: if (!V0) begin kind = K_RW; slot = S_SEC;  end
            12'h010: if (!V0) begin kind = K_RW; slot = S_FDIV; end
            12'h014: if (!V0) begin kind = K_RW; slot = S_SDIV; end
            12'h018: if (!V0) begin kind = K_RW; slot = S_CFRC; end
            12'h100: begin kind = K_RW; slot = S_RSYN; end
            12'h104: begin kind = K_RW; slot = S_RMSK; end
            12'h108: kind = K_SWRST;
            12'h10C: begin kind = K_RW; slot = S_RET; end
            12'h110: begin kind = V2 ? K_VLOCK : K_RW; slot = S_VEC0; end
            12'h114: if (V1) begin kind = K_RW; slot = S_VEC1; end
            12'h118: if (!V2) begin kind = K_HOLD; slot = S_HOLD; end
            12'h11C: begin
                if (V0) kind = K_ZERO;
                else if (V1) begin kind = K_RW; slot = S_NMI; end
            end
            12'h120: begin
                if (V2) begin kind = K_HOLD; slot = S_HOLD; end
                else    begin kind = K_RW;   slot = S_WAKE; end
            end
            12'h124: begin
                if (V1)      begin kind = K_RW; slot = S_EWC; end
                else if (V2) begin kind = K_RW; slot = S_NMI; end
            end
            12'h1FC: if (V2) begin kind = K_PLOCK; slot = S_PWR; end
            12'h200: if (!V0) begin kind = K_RW; slot = S_SSYS; end
            12'h204: if (V2)  begin kind = K_RW; slot = S_SCPU; end
            12'h20C: if (V1)  begin kind = K_RW; slot = S_SR0;  end
            12'h210: if (V1)  begin kind = K_RW; slot = S_SR1;  end
            12'h214: if (!V0) begin kind = K_RW; slot = S_SR2;  end
            12'h218: if (!V0) begin kind = K_RW; slot = S_SR3;  end
            default: if (addr >= 12'hFD0 && addr[1:0] == 2'b00) kind = K_ID;
        endcase
    end
endmodule

// File: rtl/sysctl_idrom.sv
module sysctl_idrom
    import sysctl_pkg::*;
#(
    parameter int VARIANT = 1
) (
    input  logic [3:0]    idx,
    output logic [DW-1:0] word
);
    localparam logic [7:0] REV = (VARIANT == 0) ? 8'h0B : 8'h1B;

    always_comb begin
        word = '0;
        case (idx)
            4'd0:  word[7:0] = 8'h04;
            4'd4:  word[7:0] = 8'h54;
            4'd5:  word[7:0] = 8'hB8;
            4'd6:  word[7:0] = REV;
            4'd8:  word[7:0] = 8'h0D;
            4'd9:  word[7:0] = 8'hF0;
            4'd10: word[7:0] = 8'h05;
            4'd11: word[7:0] = 8'hB1;
            default: word = '0;
        endcase
    end
endmodule

// File: rtl/sysctl_release.sv
module sysctl_release #(
    parameter int          NC       = 2,
    parameter logic [NC-1:0] RST_BITS = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NC-1:0] hold,
    output logic [NC-1:0] pulse
);
    logic [NC-1:0] prev_q, prev_d;

    always_comb begin
        prev_d = hold;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_BITS;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < NC; i++) begin : g_edge
        assign pulse[i] = prev_q[i] & ~hold[i];
    end
endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
    import sysctl_pkg::*;
#(
    parameter int          VARIANT   = 1,
    parameter int          MAX_CORES = 2,
    parameter logic [31:0] VEC0_RST  = 32'h1000_0000,
    parameter logic [31:0] VEC1_RST  = 32'h1000_0000,
    parameter logic [31:0] HOLD_RST  = 32'h0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en,
    input  logic                 wr_en,
    input  logic [11:0]          addr,
    input  logic [31:0]          wdata,
    input  logic [3:0]           wstrb,
    output logic [31:0]          rdata,
    output logic                 err,
    output logic                 sys_reset_req,
    output logic [MAX_CORES-1:0] core_hold,
    output logic [MAX_CORES-1:0] core_release,
    output logic [31:0]          init_vec0,
    output logic [31:0]          init_vec1,
    output logic [31:0]          dbg_en,
    output logic [1:0]           pwr_ctl
);
    localparam int NCORE = (VARIANT == 2) ? 1 : 2;
    localparam int SWRST_BIT = 9;
    localparam int VEC_LSB   = 7;

    kind_e         kind;
    slot_e         slot;
    logic [3:0]    id_idx;
    logic [DW-1:0] id_word;
    logic [4:0]    sidx;
    logic [DW-1:0] wmask, merged, wbits;
    logic          vec0_lock;
    bank_t         state_d, state_q;

    sysctl_decode #(.VARIANT(VARIANT)) u_dec (
        .addr(addr), .kind(kind), .slot(slot), .id_idx(id_idx)
    );

    sysctl_idrom #(.VARIANT(VARIANT)) u_id (
        .idx(id_idx), .word(id_word)
    );

    function automatic bank_t reset_state();
        bank_t s;
        s = '0;
        s.r[S_RSYN] = 32'h1;
        s.r[S_PWR]  = 32'h3;
        s.r[S_SSYS] = 32'h7F;
        s.r[S_VEC0] = VEC0_RST;
        s.r[S_VEC1] = VEC1_RST;
        s.r[S_HOLD] = HOLD_RST;
        return s;
    endfunction

    always_comb begin
        state_d        = state_q;
        state_d.err    = 1'b0;
        state_d.rstreq = 1'b0;
        sidx   = (slot == S_NONE) ? 5'd0 : 5'(slot);
        wmask  = lane_mask(wstrb);
        wbits  = wdata & wmask;
        merged = (state_q.r[sidx] & ~wmask) | wbits;

        if (rd_en) begin
            state_d.rdata = '0;
            case (kind)
                K_RW, K_RO, K_HOLD, K_VLOCK, K_PLOCK: state_d.rdata = state_q.r[sidx];
                K_ID:   state_d.rdata = id_word;
                K_ZERO: state_d.rdata = '0;
                default: state_d.err = 1'b1;
            endcase
        end

        if (wr_en) begin
            case (kind)
                K_RW, K_HOLD: state_d.r[sidx] = merged;
                K_SET:   state_d.r[S_DBG] = state_q.r[S_DBG] | wbits;
                K_CLR:   state_d.r[S_DBG] = state_q.r[S_DBG] & ~wbits;
                K_SWRST: state_d.rstreq = wbits[SWRST_BIT];
                K_VLOCK: begin
                    if (state_q.r[S_VEC0][0]) state_d.err = 1'b1;
                    else                      state_d.r[sidx] = merged;
                end
                K_PLOCK: begin
                    if (!state_q.r[S_PWR][0]) state_d.err = 1'b1;
                    else                      state_d.r[sidx] = merged;
                end
                default: state_d.err = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= reset_state();
        else        state_q <= state_d;
    end

    for (genvar i = 0; i < MAX_CORES; i++) begin : g_hold
        if (i < NCORE) begin : g_on
            assign core_hold[i] = state_q.r[S_HOLD][i];
        end else begin : g_off
            assign core_hold[i] = 1'b0;
        end
    end

    sysctl_release #(
        .NC(MAX_CORES),
        .RST_BITS(MAX_CORES'(HOLD_RST & ((VARIANT == 2) ? 32'h1 : 32'h3)))
    ) u_rel (
        .clk(clk), .rst_n(rst_n), .hold(core_hold), .pulse(core_release)
    );

    if (VARIANT == 2) begin : g_vlock
        assign init_vec0 = {state_q.r[S_VEC0][31:VEC_LSB], {VEC_LSB{1'b0}}};
        assign vec0_lock = state_q.r[S_VEC0][0];
    end else begin : g_vfree
        assign init_vec0 = state_q.r[S_VEC0];
        assign vec0_lock = 1'b0;
    end

    assign init_vec1     = state_q.r[S_VEC1];
    assign dbg_en        = state_q.r[S_DBG];
    assign pwr_ctl       = state_q.r[S_PWR][1:0];
    assign rdata         = state_q.rdata;
    assign err           = state_q.err;
    assign sys_reset_req = state_q.rstreq;
endmodule

// File: rtl/sysctl_bank_chk.sv
module sysctl_bank_chk #(
    parameter int VARIANT   = 1,
    parameter int MAX_CORES = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rd_en,
    input logic                 wr_en,
    input logic [11:0]          addr,
    input logic [31:0]          wdata,
    input logic [3:0]           wstrb,
    input logic                 err,
    input logic                 sys_reset_req,
    input logic [MAX_CORES-1:0] core_hold,
    input logic [MAX_CORES-1:0] core_release,
    input logic [31:0]          init_vec0,
    input logic [31:0]          dbg_en,
    input logic [1:0]           pwr_ctl,
    input logic                 vec0_lock
);
    // R3
    rst_req_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |-> $past(wr_en && addr == 12'h108 && wstrb[1] && wdata[9]));

    // R6
    release0_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_release[0] |-> ($past(core_hold[0]) && !core_hold[0]));

    // R6
    release_top_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_release[MAX_CORES-1] |-> ($past(core_hold[MAX_CORES-1]) && !core_hold[MAX_CORES-1]));

    // R8
    pwr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (VARIANT == 2 && !pwr_ctl[0]) |=> $stable(pwr_ctl));

    // R5
    vec_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec0_lock |=> (vec0_lock && $stable(init_vec0)));

    // R11
    err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(rd_en || wr_en));

    // R2
    dbg_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 12'h008 && wstrb == 4'hF) |=> ((dbg_en & $past(wdata)) == 32'h0));
endmodule

bind sysctl_bank sysctl_bank_chk #(.VARIANT(VARIANT), .MAX_CORES(MAX_CORES)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .wstrb(wstrb), .err(err), .sys_reset_req(sys_reset_req),
    .core_hold(core_hold), .core_release(core_release), .init_vec0(init_vec0),
    .dbg_en(dbg_en), .pwr_ctl(pwr_ctl), .vec0_lock(vec0_lock)
);

// File: tb/sysctl_bank_test.sv
`timescale 1ns/1ps
module sysctl_bank_test;
    localparam int KB = 0, KRW = 1, KRO = 2, KZ = 3, KS = 4, KC = 5, KSW = 6,
                   KH = 7, KVL = 8, KPL = 9, KID = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_en = 1'b0, wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;

    logic [31:0] rd [3];
    logic        er [3];
    logic        srq [3];
    logic [1:0]  hold [3];
    logic [1:0]  rel [3];
    logic [31:0] v0 [3];
    logic [31:0] v1 [3];
    logic [31:0] dbg [3];
    logic [1:0]  pwr [3];

    int n_chk = 0, n_err = 0;
    bit done = 0;
    logic [31:0] m [3][1024];

    always #2.5 clk = ~clk;

    sysctl_bank #(.VARIANT(1)) uut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .wstrb(wstrb), .rdata(rd[1]), .err(er[1]),
        .sys_reset_req(srq[1]), .core_hold(hold[1]), .core_release(rel[1]),
        .init_vec0(v0[1]), .init_vec1(v1[1]), .dbg_en(dbg[1]), .pwr_ctl(pwr[1]));

    sysctl_bank #(.VARIANT(0), .HOLD_RST(32'h3)) u_v0 (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .wstrb(wstrb), .rdata(rd[0]), .err(er[0]),
        .sys_reset_req(srq[0]), .core_hold(hold[0]), .core_release(rel[0]),
        .init_vec0(v0[0]), .init_vec1(v1[0]), .dbg_en(dbg[0]), .pwr_ctl(pwr[0]));

    sysctl_bank #(.VARIANT(2)) u_v2 (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .wstrb(wstrb), .rdata(rd[2]), .err(er[2]),
        .sys_reset_req(srq[2]), .core_hold(hold[2]), .core_release(rel[2]),
        .init_vec0(v0[2]), .init_vec1(v1[2]), .dbg_en(dbg[2]), .pwr_ctl(pwr[2]));

    function automatic int kind_of(int v, logic [11:0] off);
        if (off[1:0] != 2'b00) return KB;
        case (off)
            12'h000: return KRO;
            12'h004: return KS;
            12'h008: return KC;
            12'h00C, 12'h010, 12'h014, 12'h018: return (v != 0) ? KRW : KB;
            12'h100, 12'h104, 12'h10C: return KRW;
            12'h108: return KSW;
            12'h110: return (v == 2) ? KVL : KRW;
            12'h114: return (v == 1) ? KRW : KB;
            12'h118: return (v != 2) ? KH : KB;
            12'h11C: return (v == 0) ? KZ : ((v == 1) ? KRW : KB);
            12'h120: return (v == 2) ? KH : KRW;
            12'h124: return (v != 0) ? KRW : KB;
            12'h1FC: return (v == 2) ? KPL : KB;
            12'h200, 12'h214, 12'h218: return (v != 0) ? KRW : KB;
            12'h204: return (v == 2) ? KRW : KB;
            12'h20C, 12'h210: return (v == 1) ? KRW : KB;
            default: return (off >= 12'hFD0) ? KID : KB;
        endcase
    endfunction

    function automatic logic [31:0] id_word(int v, logic [11:0] off);
        case ((off - 12'hFD0) >> 2)
            0: return 32'h04;
            4: return 32'h54;
            5: return 32'hB8;
            6: return (v == 0) ? 32'h0B : 32'h1B;
            8: return 32'h0D;
            9: return 32'hF0;
            10: return 32'h05;
            11: return 32'hB1;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(int k);
        case (k)
            KRW: return "R4";
            KRO, KS, KC: return "R2";
            KSW: return "R3";
            KH: return "R6";
            KVL: return "R5";
            KPL: return "R8";
            KZ: return "R9";
            KID: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(bit ok, string req, int v, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s v%0d %s actual=%h expected=%h", req, v, what, act, exp);
        end
    endtask

    task automatic check_ports();
        for (int v = 0; v < 3; v++) begin
            logic [31:0] hm, ev0;
            hm  = m[v][(v == 2 ? 12'h120 : 12'h118) >> 2] & ((v == 2) ? 32'h1 : 32'h3);
            ev0 = (v == 2) ? (m[v][12'h110 >> 2] & 32'hFFFF_FF80) : m[v][12'h110 >> 2];
            chk(dbg[v] == m[v][0], "R2", v, "dbg_en", dbg[v], m[v][0]);
            chk(v0[v] == ev0, "R5", v, "init_vec0", v0[v], ev0);
            chk(v1[v] == m[v][12'h114 >> 2], "R4", v, "init_vec1", v1[v], m[v][12'h114 >> 2]);
            chk(pwr[v] == m[v][12'h1FC >> 2][1:0], "R8", v, "pwr_ctl", {30'b0, pwr[v]}, m[v][12'h1FC >> 2]);
            chk({30'b0, hold[v]} == hm, "R6", v, "core_hold", {30'b0, hold[v]}, hm);
        end
    endtask

    task automatic model_reset();
        for (int v = 0; v < 3; v++) begin
            for (int i = 0; i < 1024; i++) m[v][i] = '0;
            m[v][12'h100 >> 2] = 32'h1;
            m[v][12'h1FC >> 2] = 32'h3;
            m[v][12'h200 >> 2] = 32'h7F;
            m[v][12'h110 >> 2] = 32'h1000_0000;
            m[v][12'h114 >> 2] = 32'h1000_0000;
        end
        m[0][12'h118 >> 2] = 32'h3;
    endtask

    task automatic bus_write(logic [11:0] off, logic [31:0] d, logic [3:0] s);
        logic        e_err [3];
        logic [1:0]  e_rel [3];
        logic        e_srq [3];
        logic [31:0] mk;
        mk = {{8{s[3]}}, {8{s[2]}}, {8{s[1]}}, {8{s[0]}}};
        for (int v = 0; v < 3; v++) begin
            int k;
            logic [31:0] old, nw;
            k = kind_of(v, off);
            old = m[v][off >> 2];
            nw = (old & ~mk) | (d & mk);
            e_err[v] = 1'b0; e_rel[v] = 2'b00; e_srq[v] = 1'b0;
            case (k)
                KRW: m[v][off >> 2] = nw;
                KH: begin
                    e_rel[v] = 2'(old & ~nw & ((v == 2) ? 32'h1 : 32'h3));
                    m[v][off >> 2] = nw;
                end
                KS: m[v][0] = m[v][0] | (d & mk);
                KC: m[v][0] = m[v][0] & ~(d & mk);
                KSW: e_srq[v] = mk[9] & d[9];
                KVL: if (old[0]) e_err[v] = 1'b1; else m[v][off >> 2] = nw;
                KPL: if (!old[0]) e_err[v] = 1'b1; else m[v][off >> 2] = nw;
                default: e_err[v] = 1'b1;
            endcase
        end
        addr = off; wdata = d; wstrb = s; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        for (int v = 0; v < 3; v++) begin
            string t;
            t = tag_of(kind_of(v, off));
            chk(er[v] == e_err[v], (e_err[v] ? "R11" : t), v, $sformatf("err wr %h", off), {31'b0, er[v]}, {31'b0, e_err[v]});
            chk(rel[v] == e_rel[v], "R6", v, $sformatf("release wr %h", off), {30'b0, rel[v]}, {30'b0, e_rel[v]});
            chk(srq[v] == e_srq[v], "R3", v, $sformatf("reset req wr %h", off), {31'b0, srq[v]}, {31'b0, e_srq[v]});
        end
        check_ports();
    endtask

    task automatic bus_read(logic [11:0] off);
        addr = off; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        for (int v = 0; v < 3; v++) begin
            int k;
            logic [31:0] ed;
            logic ee;
            k = kind_of(v, off);
            ee = (k == KS || k == KC || k == KSW || k == KB);
            case (k)
                KRW, KRO, KH, KVL, KPL: ed = m[v][off >> 2];
                KID: ed = id_word(v, off);
                default: ed = '0;
            endcase
            chk(rd[v] == ed, tag_of(k), v, $sformatf("rdata %h", off), rd[v], ed);
            chk(er[v] == ee, "R11", v, $sformatf("err rd %h", off), {31'b0, er[v]}, {31'b0, ee});
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        logic [11:0] offs [32];
        int seed;
        offs = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010, 12'h014, 12'h018, 12'h100,
                 12'h104, 12'h108, 12'h10C, 12'h110, 12'h114, 12'h118, 12'h11C, 12'h120,
                 12'h124, 12'h1FC, 12'h200, 12'h204, 12'h20C, 12'h210, 12'h214, 12'h218,
                 12'hFD0, 12'hFE8, 12'hFFC, 12'h300, 12'h102, 12'h111, 12'h208, 12'h110};
        seed = $urandom(32'h5EED_0017);
        model_reset();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values at the ports and through reads
        check_ports();
        foreach (offs[i]) bus_read(offs[i]);

        // R2: set and clear with lane enables
        bus_write(12'h004, 32'hFF00_FF00, 4'hF);
        bus_write(12'h008, 32'hFFFF_FFFF, 4'b0010);
        bus_read(12'h000);
        bus_write(12'h000, 32'hFFFF_FFFF, 4'hF);
        // R3: reset request only with lane 1 and bit 9
        bus_write(12'h108, 32'h0000_0200, 4'b0010);
        bus_write(12'h108, 32'h0000_0200, 4'b0001);
        bus_write(12'h108, 32'hFFFF_FDFF, 4'hF);
        // R4: partial lanes
        bus_write(12'h10C, 32'hAABB_CCDD, 4'b0101);
        bus_read(12'h10C);
        // R6 and R7: hold set then released, both offsets
        bus_write(12'h118, 32'h3, 4'hF);
        bus_write(12'h120, 32'h3, 4'hF);
        bus_write(12'h118, 32'h2, 4'hF);
        bus_write(12'h120, 32'h0, 4'hF);
        bus_write(12'h118, 32'h0, 4'hF);
        bus_read(12'h124); bus_read(12'h11C); bus_read(12'h114);
        // R5: lock then attempt overwrite
        bus_write(12'h110, 32'h2000_0081, 4'hF);
        bus_write(12'h110, 32'h3000_0000, 4'hF);
        bus_read(12'h110);
        // R8: drop unlock then attempt restore
        bus_write(12'h1FC, 32'h2, 4'hF);
        bus_write(12'h1FC, 32'h3, 4'hF);
        bus_read(12'h1FC);
        // R9, R10, R11: read-only zero, identification, invalid and misaligned
        bus_write(12'h11C, 32'h1234_5678, 4'hF);
        bus_write(12'hFE0, 32'hFFFF_FFFF, 4'hF);
        bus_write(12'h300, 32'hFFFF_FFFF, 4'hF);
        bus_write(12'h10D, 32'hFFFF_FFFF, 4'hF);
        for (int a = 12'hFD0; a <= 12'hFFC; a += 4) bus_read(12'(a));

        for (int n = 0; n < 400; n++) begin
            logic [11:0] o;
            o = offs[$urandom_range(0, 31)];
            if ($urandom_range(0, 2) != 0)
                bus_write(o, $urandom, 4'($urandom_range(0, 15)));
            bus_read(o);
        end

        done = 1;
        finish_run();
    end
endmodule